// File: doc/BRIEF.md
# High-Resolution Edge PWM Compare

This block drives one output pin with a periodic pulse. A coarse time base, the loop tick, is derived from the fast input clock through two cascaded power-of-two prescalers. A loop counter walks from zero up to a programmable maximum and wraps, which fixes the period. One pin edge, the wrap edge, always falls exactly on a loop tick. The other edge, the compare edge, is placed by a 25-bit coarse compare against the loop counter and then pushed later by a fine count of high-resolution ticks. Only the fine bits that fit inside one loop tick are used. The number of bits that count depends on the loop prescale.

The duty cycle is changed through a shadow register that holds the compare value and the fine field. The active compare pair takes the shadow contents only in the cycle the compare matches. Lowering the compare value therefore can never skip a pulse. Polarity is selectable: either the compare edge sets the pin and the wrap clears it, or the compare edge clears it and the wrap sets it. An enable input forces the pin low.

Top module: `hr_edge_pwm`

## Requirements
- R1: A high-resolution tick occurs every 2^`hr_sel` clocks and a loop tick every 2^(`hr_sel`+`lr_sel`) clocks. The pin period is (`max_val`+1) loop ticks.
- R2: The loop counter advances on each loop tick and returns to 0 after the tick on which it equals `max_val`. That wrap tick applies the wrap level to the pin with no fine delay (0 when `pulse_low`=0, 1 when `pulse_low`=1).
- R3: A loop tick on which the counter equals the active compare value arms the fine delay d. The compare level is applied d high-resolution ticks after the following loop tick. With `pulse_low`=0 the high time is (`max_val`−cmp−1)·T − d·2^`hr_sel` clocks, where T is the loop tick length.
- R4: The fine delay is the active 7-bit fine field shifted right by max(0, 7−`lr_sel`). Bits below that shift have no effect.
- R5: A fine delay of 0 applies the compare level on the loop tick after the match.
- R6: A write with `shd_wr` updates only the shadow pair. The active compare and fine values take the shadow contents in the cycle of a compare match. When the compare value is lowered, no period loses its pulse.
- R7: With `pulse_low`=1, the compare event drives the pin to 0 and the wrap drives it to 1.
- R8: While `en`=0 the pin is 0.
- R9: An active compare value greater than `max_val` produces no compare event. The pin stays at the wrap level.
- R10: When the compare level and the wrap fall in the same cycle, the wrap level wins.
- R11: While `rst` is high (synchronous), all counters, the shadow pair, the active pair and the pin are cleared. The pin is 0 on the cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst | input | 1 | Synchronous active-high reset |
| hr_sel | input | 2 | High-resolution prescale exponent (1, 2, 4, 8 clocks) |
| lr_sel | input | 3 | Loop prescale exponent (1 to 128 high-resolution ticks) |
| max_val | input | 25 | Loop counter maximum |
| pulse_low | input | 1 | 0: compare sets and wrap clears; 1: the reverse |
| en | input | 1 | Output enable; 0 holds the pin low |
| shd_wr | input | 1 | Shadow write strobe |
| shd_cmp | input | 25 | Coarse compare value written to the shadow |
| shd_fine | input | 7 | Fine delay field written to the shadow |
| pin | output | 1 | PWM output |

## Verification
The delayed compare edge and the loop-counter wrap can land in the same cycle. This happens when the compare sits one tick below the maximum and its fine delay is zero. The bench sets up exactly that case and expects the pin to sit at the wrap level for whole periods. It then gives the same compare a one-tick fine delay, so the compare edge lands just after the wrap. The expected high time is then the full period minus that one fine tick, which confirms the ordering between the two events.

// File: rtl/hrpwm_pkg.sv
package hrpwm_pkg;

   typedef enum logic [1:0] {
      DLY_IDLE  = 2'd0,
      DLY_ARMED = 2'd1,
      DLY_RUN   = 2'd2
   } dly_state_e;

   // Number of low fine bits discarded for a given loop-prescale exponent.
   function automatic int unsigned drop_bits(int unsigned fine_w, int unsigned lsel);
      return (lsel >= fine_w) ? 0 : fine_w - lsel;
   endfunction

endpackage

// File: rtl/hrpwm_prescale.sv
module hrpwm_prescale #(
   parameter int unsigned HR_SEL_W = 2,
   parameter int unsigned LR_SEL_W = 3
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [HR_SEL_W-1:0] hr_sel,
   input  logic [LR_SEL_W-1:0] lr_sel,
   output logic                hr_tick,
   output logic                lr_tick
);
   localparam int unsigned HRD_W = (2 ** HR_SEL_W) - 1;
   localparam int unsigned LRD_W = (2 ** LR_SEL_W) - 1;

   generate
      if (HR_SEL_W < 1 || HR_SEL_W > 4) begin : g_bad_hr
         $error("HR_SEL_W out of range");
      end
      if (LR_SEL_W < 1 || LR_SEL_W > 4) begin : g_bad_lr
         $error("LR_SEL_W out of range");
      end
   endgenerate

   logic [HRD_W-1:0] hr_div, hr_lim;
   logic [LRD_W-1:0] lr_div, lr_lim;

   always_comb begin
      hr_lim  = HRD_W'((32'd1 << hr_sel) - 32'd1);
      lr_lim  = LRD_W'((32'd1 << lr_sel) - 32'd1);
      hr_tick = (hr_div == hr_lim);
      lr_tick = hr_tick && (lr_div == lr_lim);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         hr_div <= '0;
         lr_div <= '0;
      end else if (hr_tick) begin
         hr_div <= '0;
         lr_div <= (lr_div == lr_lim) ? '0 : lr_div + 1'b1;
      end else begin
         hr_div <= hr_div + 1'b1;
      end
   end

   AST_LR_ON_HR: assert property (@(posedge clk) disable iff (rst)
      lr_tick |-> hr_tick); // R1
   AST_HR_RESTART: assert property (@(posedge clk) disable iff (rst)
      hr_tick |=> (hr_div == '0)); // R1

endmodule

// File: rtl/hrpwm_loopcnt.sv
module hrpwm_loopcnt #(
   parameter int unsigned CMP_W = 25
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             lr_tick,
   input  logic [CMP_W-1:0] max_val,
   input  logic [CMP_W-1:0] cmp_val,
   output logic             wrap,
   output logic             match
);
   logic [CMP_W-1:0] cnt;
   logic             at_max;

   always_comb begin
      at_max = (cnt == max_val);
      wrap   = lr_tick && at_max;
      match  = lr_tick && (cnt == cmp_val);
   end

   always_ff @(posedge clk) begin
      if (rst)          cnt <= '0;
      else if (lr_tick) cnt <= at_max ? '0 : cnt + 1'b1;
   end

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
      cnt <= max_val); // R2
   AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
      wrap |=> (cnt == '0)); // R2

endmodule

// File: rtl/hrpwm_fine.sv
module hrpwm_fine
   import hrpwm_pkg::*;
#(
   parameter int unsigned FINE_W   = 7,
   parameter int unsigned LR_SEL_W = 3
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                hr_tick,
   input  logic                lr_tick,
   input  logic                load,
   input  logic [FINE_W-1:0]   fine_val,
   input  logic [LR_SEL_W-1:0] lr_sel,
   output logic                fire
);
   localparam int unsigned NSEL = 2 ** LR_SEL_W;

   logic [FINE_W-1:0] shv [NSEL];
   logic [FINE_W-1:0] dly, dcnt;
   dly_state_e        state;

   generate
      for (genvar k = 0; k < NSEL; k++) begin : g_shift
         localparam int unsigned DROP = drop_bits(FINE_W, k);
         assign shv[k] = fine_val >> DROP;
      end
   endgenerate

   always_comb begin
      dly  = shv[lr_sel];
      fire = ((state == DLY_ARMED) && lr_tick && (dcnt == '0)) ||
             ((state == DLY_RUN)   && hr_tick && (dcnt == FINE_W'(1)));
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state <= DLY_IDLE;
         dcnt  <= '0;
      end else if (load) begin
         state <= DLY_ARMED;
         dcnt  <= dly;
      end else begin
         case (state)
            DLY_ARMED: if (lr_tick) state <= (dcnt == '0) ? DLY_IDLE : DLY_RUN;
            DLY_RUN: if (hr_tick) begin
               if (dcnt == FINE_W'(1)) begin
                  state <= DLY_IDLE;
                  dcnt  <= '0;
               end else begin
                  dcnt <= dcnt - 1'b1;
               end
            end
            default: state <= DLY_IDLE;
         endcase
      end
   end

   AST_RUN_NONZERO: assert property (@(posedge clk) disable iff (rst)
      (state == DLY_RUN) |-> (dcnt != '0)); // R3
   AST_DLY_FITS: assert property (@(posedge clk) disable iff (rst)
      load |-> ((dly >> lr_sel) == '0)); // R4

endmodule

// File: rtl/hr_edge_pwm.sv
module hr_edge_pwm #(
   parameter int unsigned CMP_W    = 25,
   parameter int unsigned FINE_W   = 7,
   parameter int unsigned HR_SEL_W = 2,
   parameter int unsigned LR_SEL_W = 3
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [HR_SEL_W-1:0] hr_sel,
   input  logic [LR_SEL_W-1:0] lr_sel,
   input  logic [CMP_W-1:0]    max_val,
   input  logic                pulse_low,
   input  logic                en,
   input  logic                shd_wr,
   input  logic [CMP_W-1:0]    shd_cmp,
   input  logic [FINE_W-1:0]   shd_fine,
   output logic                pin
);
   generate
      if (CMP_W < 1 || CMP_W > 32) begin : g_bad_cmp
         $error("CMP_W out of range");
      end
      if (FINE_W < 1) begin : g_bad_fine
         $error("FINE_W must be positive");
      end
   endgenerate

   logic              hr_tick, lr_tick, wrap, match, fire;
   logic [CMP_W-1:0]  sh_cmp, act_cmp;
   logic [FINE_W-1:0] sh_fine, act_fine;
   logic              pin_q;

   hrpwm_prescale #(.HR_SEL_W(HR_SEL_W), .LR_SEL_W(LR_SEL_W)) u_pre (
      .clk(clk), .rst(rst), .hr_sel(hr_sel), .lr_sel(lr_sel),
      .hr_tick(hr_tick), .lr_tick(lr_tick));

   hrpwm_loopcnt #(.CMP_W(CMP_W)) u_loop (
      .clk(clk), .rst(rst), .lr_tick(lr_tick), .max_val(max_val),
      .cmp_val(act_cmp), .wrap(wrap), .match(match));

   hrpwm_fine #(.FINE_W(FINE_W), .LR_SEL_W(LR_SEL_W)) u_fine (
      .clk(clk), .rst(rst), .hr_tick(hr_tick), .lr_tick(lr_tick),
      .load(match), .fine_val(act_fine), .lr_sel(lr_sel), .fire(fire));

   // Shadow pair accepts writes; active pair follows it only on a match.
   always_ff @(posedge clk) begin
      if (rst) begin
         sh_cmp   <= '0;
         sh_fine  <= '0;
         act_cmp  <= '0;
         act_fine <= '0;
      end else begin
         if (shd_wr) begin
            sh_cmp  <= shd_cmp;
            sh_fine <= shd_fine;
         end
         if (match) begin
            act_cmp  <= sh_cmp;
            act_fine <= sh_fine;
         end
      end
   end

   // Wrap level has priority over a compare edge in the same cycle.
   always_ff @(posedge clk) begin
      if (rst)       pin_q <= 1'b0;
      else if (wrap) pin_q <= pulse_low;
      else if (fire) pin_q <= ~pulse_low;
   end

   assign pin = en & pin_q;

   AST_RST_PIN: assert property (@(posedge clk)
      rst |=> !pin); // R11
   AST_EN_GATE: assert property (@(posedge clk) disable iff (rst)
      !en |-> !pin); // R8
   AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (rst)
      !match |=> ($stable(act_cmp) && $stable(act_fine))); // R6
   AST_WRAP_LEVEL: assert property (@(posedge clk) disable iff (rst)
      wrap |=> (pin_q == $past(pulse_low))); // R10
   AST_FIRE_LEVEL: assert property (@(posedge clk) disable iff (rst)
      (fire && !wrap) |=> (pin_q == !$past(pulse_low))); // R3

endmodule

// File: tb/tb_hr_edge_pwm.sv
module tb_hr_edge_pwm;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [1:0]  hr_sel = '0;
   logic [2:0]  lr_sel = '0;
   logic [24:0] max_val = '0;
   logic        pulse_low = 1'b0;
   logic        en = 1'b1;
   logic        shd_wr = 1'b0;
   logic [24:0] shd_cmp = '0;
   logic [6:0]  shd_fine = '0;
   logic        pin;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;
   localparam int LIM = 4000;

   always #2 clk = ~clk; // 250 MHz

   hr_edge_pwm dut (
      .clk(clk), .rst(rst), .hr_sel(hr_sel), .lr_sel(lr_sel),
      .max_val(max_val), .pulse_low(pulse_low), .en(en),
      .shd_wr(shd_wr), .shd_cmp(shd_cmp), .shd_fine(shd_fine), .pin(pin));

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic setup(input int hs, input int ls, input int mx, input bit pl,
                        input int cmp, input int fine);
      int per;
      per = (mx + 1) << (hs + ls);
      @(negedge clk);
      rst = 1'b1; en = 1'b1; shd_wr = 1'b0;
      hr_sel = 2'(hs); lr_sel = 3'(ls); max_val = 25'(mx); pulse_low = pl;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      shd_wr = 1'b1; shd_cmp = 25'(cmp); shd_fine = 7'(fine);
      @(negedge clk);
      shd_wr = 1'b0;
      repeat (3 * per) @(negedge clk);
   endtask

   // Length of a run at level lvl and the full period, in clocks.
   task automatic measure(input string tag, input logic lvl,
                          input int exp_len, input int exp_per);
      int len = 0, per = 0, t = 0;
      while (pin === lvl && t < LIM) begin @(negedge clk); t++; end
      while (pin !== lvl && t < LIM) begin @(negedge clk); t++; end
      while (pin === lvl && t < LIM) begin len++; @(negedge clk); t++; end
      per = len;
      while (pin !== lvl && t < LIM) begin per++; @(negedge clk); t++; end
      check({tag, " run length"}, len, exp_len);
      check({tag, " period"}, per, exp_per);
   endtask

   task automatic count_ones(input int n, output int ones);
      ones = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (pin === 1'b1) ones++;
      end
   endtask

   task automatic t_reset;
      @(negedge clk);
      rst = 1'b1;
      repeat (3) @(negedge clk);
      check("R11 pin during reset", int'(pin), 0);
      rst = 1'b0;
      @(negedge clk);
      check("R11 pin after reset", int'(pin), 0);
   endtask

   task automatic t_base;
      setup(1, 2, 4, 1'b0, 1, 'h40);
      measure("R3 R1 R2 base 0x40", 1'b1, 12, 40);
      setup(1, 2, 4, 1'b0, 1, 'h5F);
      measure("R4 low bits ignored", 1'b1, 12, 40);
      setup(0, 3, 4, 1'b0, 1, 'h35);
      measure("R4 R1 loop prescale 8", 1'b1, 13, 40);
      setup(2, 0, 9, 1'b0, 2, 'h7F);
      measure("R4 R1 all fine bits dropped", 1'b1, 24, 40);
   endtask

   task automatic t_zero_delay;
      setup(1, 2, 4, 1'b0, 1, 0);
      measure("R5 zero fine delay", 1'b1, 16, 40);
   endtask

   task automatic t_polarity;
      setup(1, 2, 4, 1'b1, 1, 'h40);
      measure("R7 pulse-low", 1'b0, 12, 40);
   endtask

   task automatic t_enable;
      int ones;
      setup(1, 2, 4, 1'b0, 1, 'h40);
      en = 1'b0;
      count_ones(80, ones);
      check("R8 disabled pin", ones, 0);
      en = 1'b1;
      measure("R8 re-enabled", 1'b1, 12, 40);
   endtask

   task automatic t_shadow;
      int t = 0, rises = 0, gap = 0, maxgap = 0;
      logic prev;
      setup(1, 2, 7, 1'b0, 5, 0);
      measure("R6 before update", 1'b1, 8, 64);
      while (pin !== 1'b1 && t < LIM) begin @(negedge clk); t++; end
      while (pin !== 1'b0 && t < LIM) begin @(negedge clk); t++; end
      repeat (24) @(negedge clk);
      shd_wr = 1'b1; shd_cmp = 25'd1; shd_fine = 7'd0;
      @(negedge clk);
      shd_wr = 1'b0;
      prev = pin;
      for (int i = 0; i < 256; i++) begin
         @(negedge clk);
         gap++;
         if (pin === 1'b1 && prev === 1'b0) begin
            rises++;
            if (rises > 1 && gap > maxgap) maxgap = gap;
            gap = 0;
         end
         prev = pin;
      end
      check("R6 pulses present after lowering", int'(rises >= 3), 1);
      check("R6 no dropped pulse", int'(maxgap <= 64), 1);
      measure("R6 after update", 1'b1, 40, 64);
   endtask

   task automatic t_beyond_max;
      int ones;
      setup(1, 2, 4, 1'b0, 6, 0);
      count_ones(80, ones);
      check("R9 compare above max, pulse-high", ones, 0);
      setup(1, 2, 4, 1'b1, 6, 0);
      count_ones(80, ones);
      check("R9 compare above max, pulse-low", ones, 80);
   endtask

   task automatic t_collision;
      int ones;
      setup(1, 2, 4, 1'b0, 3, 0);
      count_ones(80, ones);
      check("R10 wrap wins same-cycle edge", ones, 0);
      setup(1, 2, 4, 1'b0, 3, 'h20);
      measure("R10 edge just after wrap", 1'b1, 38, 40);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_base();
      t_zero_delay();
      t_polarity();
      t_enable();
      t_shadow();
      t_beyond_max();
      t_collision();
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule